// File: doc/BRIEF.md
# Receive FIFO with Error-Tag Counters

This block sits behind an asynchronous serial receiver and buffers up to 64 received bytes. Each byte is stored with two tags: one marks a parity error and one marks a framing error. For each tag type the block keeps a live count of the stored entries that carry that tag. A push of a tagged entry raises the count and a pop of one lowers it, so the count always describes what the FIFO holds at that moment.

The two counts appear in a 16-bit read-only status word. The parity count occupies bits 13:8 and the framing count occupies bits 5:0. Each count is 6 bits wide and wraps, so a FIFO that holds 64 entries all carrying the same tag shows zero for that tag. The head entry is presented at the pop port together with its two tags, so a consumer can tell which byte was bad. When the receiver runs in clocked synchronous mode the tags are not recorded and both counts stay at zero.

Top module: `rx_err_fifo`

## Requirements
- R1: After rst_ni is deasserted, or in the cycle after flush_i is sampled high, empty_o is 1, full_o is 0, overrun_o is 0 and status_o is 0; flush_i takes priority over any push or pop in the same cycle.
- R2: Bytes leave in the order they were accepted, and the oldest byte is driven on pop_data_o whenever empty_o is 0.
- R3: full_o is 1 exactly when 64 entries are held; a push while full with no accepted pop is dropped, leaves the status word unchanged, and sets overrun_o high for the following cycle only.
- R4: status_o[13:8] equals, modulo 64, the number of held entries whose parity tag is set.
- R5: status_o[5:0] equals, modulo 64, the number of held entries whose framing tag is set.
- R6: status_o[15:14] and status_o[7:6] are always 0.
- R7: With 64 held entries that all carry a given tag, that tag's 6-bit field reads 0, and it reads 63 after one of them is popped.
- R8: While async_mode_i is 0, pushed entries are stored with both tags cleared, so pushes do not change status_o and the stored entries pop with both tags at 0.
- R9: A push and a pop accepted in the same cycle change each count by the difference of the two tags, so a tagged entry in and a tagged entry out leave it unchanged; when full, a push together with a pop is accepted.
- R10: pop_perr_o and pop_ferr_o give the tags of the entry shown on pop_data_o.
- R11: A pop while empty has no effect: empty_o stays 1 and status_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous clear of entries and counts |
| async_mode_i | input | 1 | 1: asynchronous mode, tags recorded; 0: tags cleared on push |
| push_i | input | 1 | Push request |
| push_data_i | input | 8 | Received byte |
| push_perr_i | input | 1 | Parity error tag of the pushed byte |
| push_ferr_i | input | 1 | Framing error tag of the pushed byte |
| pop_i | input | 1 | Pop request for the head entry |
| pop_data_o | output | 8 | Head byte |
| pop_perr_o | output | 1 | Parity tag of the head byte |
| pop_ferr_o | output | 1 | Framing tag of the head byte |
| full_o | output | 1 | 64 entries held |
| empty_o | output | 1 | No entry held |
| overrun_o | output | 1 | One-cycle pulse after a dropped push |
| status_o | output | 16 | Parity count in 13:8, framing count in 5:0, other bits 0 |

## Verification
The properties assume that push_i, pop_i, flush_i and async_mode_i are settled before each rising edge. Several of them also hold only when the matching request is low, for example that the status word stays stable when neither push_i nor pop_i is set. The bench meets this by changing every input on the falling edge and by releasing push_i and pop_i after each single-cycle operation. It changes async_mode_i only between operations, and a separate test performs a simultaneous push and pop so that those cases do not mix with the idle-stability checks.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rxf_entry_t;

  localparam int unsigned N_TAGS = 2;
  localparam int unsigned TAG_P  = 1;
  localparam int unsigned TAG_F  = 0;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_en_i,
  input  rxf_entry_t wr_entry_i,
  input  logic       rd_en_i,
  output rxf_entry_t rd_entry_o,
  output logic       full_o,
  output logic       empty_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  rxf_entry_t mem_q [DEPTH];
  logic [PTR_W:0] wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en_i) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !clr_i) mem_q[wr_ptr_q[PTR_W-1:0]] <= wr_entry_i;
  end

  assign rd_entry_o = mem_q[rd_ptr_q[PTR_W-1:0]];
  assign empty_o    = (wr_ptr_q == rd_ptr_q);
  assign full_o     = (wr_ptr_q[PTR_W] != rd_ptr_q[PTR_W]) &&
                      (wr_ptr_q[PTR_W-1:0] == rd_ptr_q[PTR_W-1:0]);
endmodule

// File: rtl/rxf_tag_cnt.sv
module rxf_tag_cnt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // modulo wrap is intended: full FIFO of tagged entries reads zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !dec_i)   cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned STATUS_W = 16,
  parameter int unsigned PERR_LSB = 8,
  parameter int unsigned FERR_LSB = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                async_mode_i,
  input  logic                push_i,
  input  logic [DATA_W-1:0]   push_data_i,
  input  logic                push_perr_i,
  input  logic                push_ferr_i,
  input  logic                pop_i,
  output logic [DATA_W-1:0]   pop_data_o,
  output logic                pop_perr_o,
  output logic                pop_ferr_o,
  output logic                full_o,
  output logic                empty_o,
  output logic                overrun_o,
  output logic [STATUS_W-1:0] status_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH);

  rxf_entry_t wr_entry, rd_entry;
  logic full, empty, pop_acc, push_acc, overrun_q;
  logic [N_TAGS-1:0] tag_in, tag_out;
  logic [CNT_W-1:0]  cnt [N_TAGS];

  assign pop_acc  = pop_i && !empty && !flush_i;
  assign push_acc = push_i && (!full || pop_acc) && !flush_i;

  assign wr_entry.data = push_data_i;
  assign wr_entry.perr = push_perr_i && async_mode_i;
  assign wr_entry.ferr = push_ferr_i && async_mode_i;

  rxf_store #(.DEPTH(DEPTH)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (flush_i),
    .wr_en_i    (push_acc),
    .wr_entry_i (wr_entry),
    .rd_en_i    (pop_acc),
    .rd_entry_o (rd_entry),
    .full_o     (full),
    .empty_o    (empty)
  );

  assign tag_in[TAG_P]  = wr_entry.perr;
  assign tag_in[TAG_F]  = wr_entry.ferr;
  assign tag_out[TAG_P] = rd_entry.perr;
  assign tag_out[TAG_F] = rd_entry.ferr;

  for (genvar g = 0; g < N_TAGS; g++) begin : g_cnt
    rxf_tag_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (flush_i),
      .inc_i  (push_acc && tag_in[g]),
      .dec_i  (pop_acc && tag_out[g]),
      .cnt_o  (cnt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overrun_q <= 1'b0;
    else         overrun_q <= push_i && full && !pop_acc && !flush_i;
  end

  always_comb begin
    status_o = '0;
    status_o[PERR_LSB +: CNT_W] = cnt[TAG_P];
    status_o[FERR_LSB +: CNT_W] = cnt[TAG_F];
  end

  assign pop_data_o = rd_entry.data;
  assign pop_perr_o = rd_entry.perr && !empty;
  assign pop_ferr_o = rd_entry.ferr && !empty;
  assign full_o     = full;
  assign empty_o    = empty;
  assign overrun_o  = overrun_q;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        flush_i,
  input logic        async_mode_i,
  input logic        push_i,
  input logic        pop_i,
  input logic        full_o,
  input logic        empty_o,
  input logic        overrun_o,
  input logic [15:0] status_o
);
  p_flush_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && !full_o && status_o == 16'h0));

  p_full_empty_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  p_overrun_raise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> overrun_o);

  p_overrun_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(full_o && push_i));

  p_drop_keeps_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(status_o));

  p_idle_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i && !flush_i) |=> $stable(status_o));

  p_rsvd_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[15:14] == 2'b00 && status_o[7:6] == 2'b00));

  p_sync_no_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_mode_i && !pop_i && !flush_i) |=> $stable(status_o));

  p_empty_pop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> (empty_o && $stable(status_o)));
endmodule

bind rx_err_fifo rx_err_fifo_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .async_mode_i (async_mode_i),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .full_o       (full_o),
  .empty_o      (empty_o),
  .overrun_o    (overrun_o),
  .status_o     (status_o)
);

// File: tb/test_rx_err_fifo.sv
module test_rx_err_fifo;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0, async_mode_i = 1'b1;
  logic push_i = 1'b0, push_perr_i = 1'b0, push_ferr_i = 1'b0, pop_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic [7:0] pop_data_o;
  logic pop_perr_o, pop_ferr_o, full_o, empty_o, overrun_o;
  logic [15:0] status_o;

  int n_chk = 0, n_fail = 0;
  logic [9:0] q [$]; // {perr, ferr, data}

  always #10 clk_i = ~clk_i; // 50 MHz

  rx_err_fifo i_rx_err_fifo (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status();
    int p = 0, f = 0;
    foreach (q[i]) begin
      p += q[i][9];
      f += q[i][8];
    end
    return {2'b00, 6'(p % 64), 2'b00, 6'(f % 64)};
  endfunction

  task automatic check_state(input string req);
    chk(empty_o == (q.size() == 0), req, "empty_o", empty_o, q.size() == 0);
    chk(full_o == (q.size() == 64), req, "full_o", full_o, q.size() == 64);
    chk(status_o == exp_status(), req, "status_o", status_o, exp_status());
    if (q.size() != 0)
      chk({pop_perr_o, pop_ferr_o, pop_data_o} == q[0], req, "head",
          {pop_perr_o, pop_ferr_o, pop_data_o}, q[0]);
  endtask

  // one clock cycle of stimulus; model updated by the rules of R2, R3, R8, R9
  task automatic step(input bit psh, input logic [7:0] d, input bit p, input bit f,
                      input bit pp, input bit fl);
    bit pop_ok, push_ok;
    @(negedge clk_i);
    push_i = psh; push_data_i = d; push_perr_i = p; push_ferr_i = f;
    pop_i = pp; flush_i = fl;
    pop_ok  = pp && q.size() != 0 && !fl;
    push_ok = psh && (q.size() < 64 || pop_ok) && !fl;
    @(posedge clk_i);
    if (fl) q.delete();
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back({p && async_mode_i, f && async_mode_i, d});
    @(negedge clk_i);
    push_i = 0; pop_i = 0; flush_i = 0;
  endtask

  task automatic t_reset();
    chk(empty_o && !full_o && !overrun_o, "R1", "flags after reset",
        {empty_o, full_o, overrun_o}, 3'b100);
    chk(status_o == 16'h0, "R1", "status after reset", status_o, 0);
  endtask

  task automatic t_order();
    step(1, 8'h11, 1, 0, 0, 0);
    step(1, 8'h22, 0, 1, 0, 0);
    step(1, 8'h33, 1, 1, 0, 0);
    step(1, 8'h44, 0, 0, 0, 0);
    chk(status_o == 16'h0202, "R4", "parity/framing counts", status_o, 16'h0202);
    check_state("R5");
    for (int i = 0; i < 4; i++) begin
      check_state("R10");
      step(0, 0, 0, 0, 1, 0);
      check_state("R2");
    end
  endtask

  task automatic t_empty_pop();
    step(0, 0, 0, 0, 1, 0);
    chk(empty_o && status_o == 0, "R11", "pop on empty", {empty_o, status_o}, 17'h10000);
  endtask

  task automatic t_fill_wrap();
    for (int i = 0; i < 64; i++) step(1, 8'(i), 1, 1, 0, 0);
    chk(full_o, "R3", "full at 64", full_o, 1);
    chk(status_o == 16'h0, "R7", "wrapped counts", status_o, 0);
    step(1, 8'hEE, 0, 0, 0, 0);
    chk(overrun_o, "R3", "overrun pulse", overrun_o, 1);
    check_state("R3");
    step(0, 0, 0, 0, 0, 0);
    chk(!overrun_o, "R3", "overrun one cycle", overrun_o, 0);
    chk(status_o[15:14] == 0 && status_o[7:6] == 0, "R6", "reserved bits", status_o, 0);
    step(1, 8'h5A, 1, 1, 1, 0); // simultaneous at full: accepted
    chk(status_o == 16'h0, "R9", "push+pop at full", status_o, 0);
    check_state("R9");
    step(0, 0, 0, 0, 1, 0);
    chk(status_o == 16'h3F3F, "R7", "63 after one pop", status_o, 16'h3F3F);
    step(0, 0, 0, 0, 0, 1);
    check_state("R1");
  endtask

  task automatic t_simul();
    step(1, 8'hA1, 1, 0, 0, 0);
    step(1, 8'hA2, 0, 0, 0, 0);
    step(1, 8'hA3, 1, 0, 1, 0); // tagged in, tagged out
    chk(status_o == 16'h0100, "R9", "tagged in and out", status_o, 16'h0100);
    step(1, 8'hA4, 0, 1, 1, 0); // untagged out, framing in
    chk(status_o == 16'h0101, "R9", "net change", status_o, 16'h0101);
    check_state("R9");
    step(0, 0, 0, 0, 0, 1);
    check_state("R1");
  endtask

  task automatic t_sync();
    async_mode_i = 0;
    step(1, 8'hC3, 1, 1, 0, 0);
    step(1, 8'hC4, 1, 0, 0, 0);
    chk(status_o == 16'h0, "R8", "sync mode counts", status_o, 0);
    chk(!pop_perr_o && !pop_ferr_o && pop_data_o == 8'hC3, "R8", "sync tags",
        {pop_perr_o, pop_ferr_o, pop_data_o}, 10'h0C3);
    async_mode_i = 1;
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    check_state("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_order();
    t_empty_pop();
    t_fill_wrap();
    t_simul();
    t_sync();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule